// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Break Detection

This block recovers characters from an asynchronous serial line. The line `rxd` is sampled only in master-clock cycles where `rx_tick` is high. `rx_tick` stands for a rising edge of the receive clock and is supplied as a clock enable. A rate select makes each bit last 1, 16 or 64 ticks. In the oversampled rates the block re-checks a falling edge at mid-bit before treating it as a start bit. It then shifts in 5 to 8 data bits LSB-first, checks an optional odd or even parity bit, and checks one or two stop bits.

Each finished character goes into a single holding buffer. The block raises a ready flag and sets sticky flags for parity, overrun and framing errors. The host reads the buffer, acknowledges it with a one-cycle read strobe, and clears the errors with a one-cycle error-clear strobe. A separate detector watches for the line held low for a whole character time and reports it as a break.

Top module: `oversamp_rx`

## Requirements
- R1: After `rst_n` low (asynchronous) or a one-cycle `soft_rst` (synchronous), `rx_data`, `rx_ready`, `perr`, `oerr`, `ferr` and `brk` are all 0.
- R2: `rate_sel` 2'b10 gives 16 ticks per bit and 2'b11 gives 64. A low sample seen while idle is sampled again 8 (or 32) ticks later. If that sample is high, the receiver returns to idle and no word is produced. Otherwise each later bit is sampled every 16 (or 64) ticks. With `rate_sel` 2'b00 the receiver stays idle.
- R3: `rate_sel` 2'b01 gives 1 tick per bit: the tick after the low start sample takes data bit 0, and every following tick takes the next bit.
- R4: `len_sel` 0..3 selects 5..8 data bits. Bits are received LSB-first and presented right-aligned in `rx_data`, with the unused upper bits zero.
- R5: With `par_en`=1, a parity bit follows the data and is not stored. `par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `perr`.
- R6: A low stop sample sets `ferr` and delivers the word at once. With `stop_two`=1, two high stop samples are needed before the word is delivered.
- R7: `rx_ready` rises on the clock after the tick of the last stop sample. `buf_rd` clears it on the next clock.
- R8: A word delivered while `rx_ready` is still set, with no `buf_rd` in that cycle, sets `oerr`. The new word overwrites `rx_data`.
- R9: `err_clr` clears `perr`, `oerr` and `ferr` on the next clock, unless a delivery in that same cycle sets one of them again.
- R10: `brk` is set once `rxd` has been sampled low on N consecutive ticks, where N is the ticks per bit times (1 start + data bits + parity bit if enabled + 1 or 2 stop bits). It clears on the first tick that samples `rxd` high.
- R11: While `rx_en` is 0 the receiver stays idle and delivers nothing. Break detection keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous total reset, active low |
| soft_rst | input | 1 | Synchronous internal reset pulse |
| rx_tick | input | 1 | Receive-clock edge enable |
| rxd | input | 1 | Serial line input |
| rx_en | input | 1 | Receiver enable |
| rate_sel | input | 2 | 00 off, 01 x1, 10 x16, 11 x64 |
| len_sel | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even, 0 odd parity |
| stop_two | input | 1 | Two stop bits |
| err_clr | input | 1 | Clear error flags |
| buf_rd | input | 1 | Buffer read acknowledge |
| rx_data | output | 8 | Received word, right-aligned |
| rx_ready | output | 1 | Buffer holds an unread word |
| perr | output | 1 | Parity error flag |
| oerr | output | 1 | Overrun error flag |
| ferr | output | 1 | Framing error flag |
| brk | output | 1 | Break condition |

## Verification
The assertions assume that the rate, length, parity and stop selections change only while the receiver is idle. The bit-counter bound depends on this. They also assume that `rx_tick` is a single-cycle enable. The bench changes the format only between frames, after the line has rested high. It drives `rxd` only just after a tick edge, so every sample lands in the middle of a held bit. It raises `buf_rd` and `err_clr` for exactly one cycle.

// File: rtl/oversamp_rx_pkg.sv
package oversamp_rx_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP1 = 3'd4,
      S_STOP2 = 3'd5
   } rx_state_t;

   localparam logic [1:0] RATE_OFF = 2'b00;
   localparam logic [1:0] RATE_X1  = 2'b01;
   localparam logic [1:0] RATE_MID = 2'b10;
   localparam logic [1:0] RATE_HI  = 2'b11;
endpackage

// File: rtl/oversamp_rx_timer.sv
module oversamp_rx_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             tick,
   input  logic             restart,
   input  logic             half,
   input  logic [2:0]       shift,
   output logic             fire
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] full_len;
   logic [CNT_W-1:0] target;

   always_comb begin
      full_len = CNT_W'(1) << shift;
      target   = half ? (full_len >> 1) : full_len;
      fire     = tick && !restart && (cnt == target - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (sync_clr || restart)
         cnt <= '0;
      else if (tick)
         cnt <= fire ? '0 : cnt + CNT_W'(1);
   end

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && !sync_clr) |-> (cnt < target));
endmodule

// File: rtl/oversamp_rx_break.sv
module oversamp_rx_break #(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             tick,
   input  logic             rxd,
   input  logic [LEN_W-1:0] limit,
   output logic             brk
);
   localparam logic [LEN_W-1:0] SAT = '1;
   logic [LEN_W-1:0] low_cnt;
   logic [LEN_W-1:0] low_nxt;

   assign low_nxt = (low_cnt == SAT) ? SAT : low_cnt + LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         brk     <= 1'b0;
      end else if (sync_clr) begin
         low_cnt <= '0;
         brk     <= 1'b0;
      end else if (tick) begin
         if (rxd) begin
            low_cnt <= '0;
            brk     <= 1'b0;
         end else begin
            low_cnt <= low_nxt;
            if (low_nxt >= limit) brk <= 1'b1;
         end
      end
   end

   assert_brk_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && tick && rxd) |=> !brk);
   assert_brk_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk) |-> $past(!rxd && tick));
endmodule

// File: rtl/oversamp_rx.sv
module oversamp_rx #(
   parameter int LEN_BASE    = 5,
   parameter int LEN_SEL_W   = 2,
   parameter int DIV_MID_LOG = 4,
   parameter int DIV_HI_LOG  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       rx_tick,
   input  logic       rxd,
   input  logic       rx_en,
   input  logic [1:0] rate_sel,
   input  logic [1:0] len_sel,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       stop_two,
   input  logic       err_clr,
   input  logic       buf_rd,
   output logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       perr,
   output logic       oerr,
   output logic       ferr,
   output logic       brk
);
   import oversamp_rx_pkg::*;

   localparam int DATA_W = LEN_BASE + (1 << LEN_SEL_W) - 1;
   localparam int IDX_W  = $clog2(DATA_W + 1);
   localparam int CNT_W  = DIV_HI_LOG + 1;
   localparam int BRK_W  = DIV_HI_LOG + $clog2(DATA_W + 5) + 1;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("oversamp_rx: data width must come out as 8");
      end
      if (DIV_MID_LOG < 1 || DIV_MID_LOG >= DIV_HI_LOG || DIV_HI_LOG > 7) begin : g_bad_div
         $error("oversamp_rx: divider logs must satisfy 1 <= mid < hi <= 7");
      end
   endgenerate

   rx_state_t         state;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  bit_idx;
   logic              acc;
   logic              pend_pe;

   logic [2:0]        shift;
   logic [IDX_W-1:0]  wlen;
   logic [DATA_W-1:0] aligned;
   logic [BRK_W-1:0]  frame_bits;
   logic [BRK_W-1:0]  brk_limit;
   logic              active;
   logic              fire;
   logic              xfer;

   always_comb begin
      case (rate_sel)
         RATE_MID: shift = 3'(DIV_MID_LOG);
         RATE_HI:  shift = 3'(DIV_HI_LOG);
         default:  shift = 3'd0;
      endcase
      wlen       = IDX_W'(LEN_BASE) + IDX_W'(len_sel);
      aligned    = shreg >> (IDX_W'(DATA_W) - wlen);
      frame_bits = BRK_W'(2 + LEN_BASE) + BRK_W'(len_sel) + BRK_W'(par_en) + BRK_W'(stop_two);
      brk_limit  = frame_bits << shift;
      active     = rx_en && (rate_sel != RATE_OFF);
      xfer       = active && fire &&
                   ((state == S_STOP1 && (!rxd || !stop_two)) || state == S_STOP2);
   end

   oversamp_rx_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (soft_rst),
      .tick     (rx_tick),
      .restart  (state == S_IDLE),
      .half     (state == S_START),
      .shift    (shift),
      .fire     (fire)
   );

   oversamp_rx_break #(.LEN_W(BRK_W)) u_break (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (soft_rst),
      .tick     (rx_tick),
      .rxd      (rxd),
      .limit    (brk_limit),
      .brk      (brk)
   );

   // framing state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         shreg   <= '0;
         bit_idx <= '0;
         acc     <= 1'b0;
         pend_pe <= 1'b0;
      end else if (soft_rst || !active) begin
         state   <= S_IDLE;
      end else begin
         case (state)
            S_IDLE: begin
               shreg   <= '0;
               bit_idx <= '0;
               acc     <= 1'b0;
               pend_pe <= 1'b0;
               if (rx_tick && !rxd)
                  state <= (rate_sel == RATE_X1) ? S_DATA : S_START;
            end
            S_START: if (fire) state <= rxd ? S_IDLE : S_DATA;
            S_DATA: if (fire) begin
               shreg   <= {rxd, shreg[DATA_W-1:1]};
               acc     <= acc ^ rxd;
               bit_idx <= bit_idx + IDX_W'(1);
               if (bit_idx == wlen - IDX_W'(1))
                  state <= par_en ? S_PAR : S_STOP1;
            end
            S_PAR: if (fire) begin
               pend_pe <= ((acc ^ rxd) == par_even);
               state   <= S_STOP1;
            end
            S_STOP1: if (fire) state <= (rxd && stop_two) ? S_STOP2 : S_IDLE;
            S_STOP2: if (fire) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // holding buffer and flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_ready <= 1'b0;
         perr     <= 1'b0;
         oerr     <= 1'b0;
         ferr     <= 1'b0;
      end else if (soft_rst) begin
         rx_data  <= '0;
         rx_ready <= 1'b0;
         perr     <= 1'b0;
         oerr     <= 1'b0;
         ferr     <= 1'b0;
      end else begin
         if (xfer) rx_data <= aligned;
         rx_ready <= xfer | (rx_ready & ~buf_rd);
         perr     <= (perr & ~err_clr) | (xfer & pend_pe);
         oerr     <= (oerr & ~err_clr) | (xfer & rx_ready & ~buf_rd);
         ferr     <= (ferr & ~err_clr) | (xfer & ~rxd);
      end
   end

   assert_rdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && !xfer) |=> !rx_ready);
   assert_oe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oerr) |-> $past(rx_ready));
   assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !xfer) |=> (!perr && !oerr && !ferr));
   assert_fe_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ferr) |-> $past(state == S_STOP1 || state == S_STOP2));
   assert_idle_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (state == S_IDLE));
endmodule

// File: tb/oversamp_rx_test.sv
module oversamp_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic rx_tick = 1'b0;
   logic rxd = 1'b1;
   logic rx_en = 1'b1;
   logic [1:0] rate_sel = 2'b10;
   logic [1:0] len_sel = 2'b11;
   logic par_en = 1'b0;
   logic par_even = 1'b0;
   logic stop_two = 1'b0;
   logic err_clr = 1'b0;
   logic buf_rd = 1'b0;
   logic [7:0] rx_data;
   logic rx_ready, perr, oerr, ferr, brk;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit auto_rd = 1'b1;
   logic [9:0] expq[$];

   oversamp_rx uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_tick(rx_tick), .rxd(rxd),
      .rx_en(rx_en), .rate_sel(rate_sel), .len_sel(len_sel), .par_en(par_en),
      .par_even(par_even), .stop_two(stop_two), .err_clr(err_clr), .buf_rd(buf_rd),
      .rx_data(rx_data), .rx_ready(rx_ready), .perr(perr), .oerr(oerr),
      .ferr(ferr), .brk(brk)
   );

   always #2.5 clk = ~clk;
   always @(negedge clk) rx_tick <= ~rx_tick;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         report();
      end
   end

   // monitor: pops the scoreboard when a word appears, then reads it and clears errors
   always @(negedge clk) begin
      if (auto_rd && rx_ready && !buf_rd) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R7 unexpected word", int'(rx_data), 0);
         end else begin
            logic [9:0] e;
            e = expq.pop_front();
            chk(rx_data == e[7:0], "R4 data", int'(rx_data), int'(e[7:0]));
            chk(perr == e[8], "R5 perr", int'(perr), int'(e[8]));
            chk(ferr == e[9], "R6 ferr", int'(ferr), int'(e[9]));
            chk(oerr == 1'b0, "R8 no overrun", int'(oerr), 0);
         end
         buf_rd  <= 1'b1;
         err_clr <= 1'b1;
      end else if (auto_rd) begin
         buf_rd  <= 1'b0;
         err_clr <= 1'b0;
      end
   end

   task automatic wait_tick();
      @(posedge clk);
      while (!rx_tick) @(posedge clk);
      #1;
   endtask

   task automatic hold(input logic v, input int n);
      rxd = v;
      for (int i = 0; i < n; i++) wait_tick();
   endtask

   function automatic int per_bit();
      case (rate_sel)
         2'b10: return 16;
         2'b11: return 64;
         default: return 1;
      endcase
   endfunction

   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit push);
      int n, ones, dv;
      logic p;
      n = 5 + int'(len_sel);
      dv = per_bit();
      ones = 0;
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      p = par_even ? logic'(ones % 2) : ~logic'(ones % 2);
      if (bad_par) p = ~p;
      if (push) expq.push_back({bad_stop, bad_par & par_en, d & 8'((1 << n) - 1)});
      hold(1'b0, dv);
      for (int i = 0; i < n; i++) hold(d[i], dv);
      if (par_en) hold(p, dv);
      hold(~bad_stop, dv);
      if (stop_two && !bad_stop) hold(1'b1, dv);
      hold(1'b1, 2 * dv + 4);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
      #1;
   endtask

   task automatic drained(input string tag);
      repeat (6) @(posedge clk);
      #1;
      chk(expq.size() == 0, tag, expq.size(), 0);
      chk(rx_ready == 1'b0, "R7 ready cleared by read", int'(rx_ready), 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      chk(rx_data == 8'h00, "R1 data after reset", int'(rx_data), 0);
      chk(rx_ready == 1'b0, "R1 ready after reset", int'(rx_ready), 0);
      chk({perr, oerr, ferr} == 3'b000, "R1 errors after reset", int'({perr, oerr, ferr}), 0);
      chk(brk == 1'b0, "R1 brk after reset", int'(brk), 0);
      rst_n = 1'b1;
      hold(1'b1, 4);

      // R2 x16, 8 data bits, no parity, one stop
      send(8'hA5, 0, 0, 1);
      send(8'h3C, 0, 0, 1);
      drained("R2 x16 words delivered");

      // R3 x1, 5 bits even parity; R4 right alignment
      rate_sel = 2'b01; len_sel = 2'b00; par_en = 1'b1; par_even = 1'b1;
      hold(1'b1, 4);
      send(8'h15, 0, 0, 1);
      send(8'h0A, 0, 0, 1);
      drained("R3 x1 words delivered");

      // R2 x64, 7 bits odd parity, two stops (R6)
      rate_sel = 2'b11; len_sel = 2'b10; par_even = 1'b0; stop_two = 1'b1;
      hold(1'b1, 4);
      send(8'h5A, 0, 0, 1);
      drained("R6 x64 two-stop word delivered");

      // R5 parity error, x16 8E1
      rate_sel = 2'b10; len_sel = 2'b11; par_even = 1'b1; stop_two = 1'b0;
      hold(1'b1, 4);
      send(8'h81, 1, 0, 1);
      drained("R5 parity error word");

      // R6 framing error, x16 8N1
      par_en = 1'b0;
      send(8'h6E, 0, 1, 1);
      drained("R6 framing error word");

      // R2 false start: low for 4 ticks only
      hold(1'b0, 4);
      hold(1'b1, 60);
      chk(rx_ready == 1'b0, "R2 false start gives no word", int'(rx_ready), 0);

      // R8 overrun, then R9 clear and R7 read
      auto_rd = 1'b0;
      @(negedge clk); buf_rd = 1'b0; err_clr = 1'b0;
      send(8'h11, 0, 0, 0);
      chk(rx_ready == 1'b1, "R7 ready after word", int'(rx_ready), 1);
      chk(oerr == 1'b0, "R8 no overrun on first", int'(oerr), 0);
      send(8'h22, 0, 0, 0);
      chk(oerr == 1'b1, "R8 overrun set", int'(oerr), 1);
      chk(rx_data == 8'h22, "R8 buffer overwritten", int'(rx_data), 8'h22);
      pulse(err_clr);
      chk(oerr == 1'b0, "R9 err_clr clears oerr", int'(oerr), 0);
      chk(rx_ready == 1'b1, "R9 err_clr leaves ready", int'(rx_ready), 1);
      pulse(buf_rd);
      chk(rx_ready == 1'b0, "R7 buf_rd clears ready", int'(rx_ready), 0);

      // R1 soft reset clears flags
      par_en = 1'b1;
      send(8'h40, 1, 0, 0);
      chk(perr == 1'b1, "R5 perr set before soft reset", int'(perr), 1);
      pulse(soft_rst);
      chk({rx_ready, perr} == 2'b00, "R1 soft reset clears", int'({rx_ready, perr}), 0);
      chk(rx_data == 8'h00, "R1 soft reset clears data", int'(rx_data), 0);
      par_en = 1'b0;

      // R2 rate 00 keeps receiver idle
      rate_sel = 2'b00;
      send(8'h0F, 0, 0, 0);
      chk(rx_ready == 1'b0, "R2 rate off gives no word", int'(rx_ready), 0);
      rate_sel = 2'b10;

      // R11 receiver disabled
      rx_en = 1'b0;
      send(8'h33, 0, 0, 0);
      chk(rx_ready == 1'b0, "R11 disabled gives no word", int'(rx_ready), 0);

      // R10 break: x16 8N1 -> 10 bits * 16 = 160 ticks
      hold(1'b0, 159);
      chk(brk == 1'b0, "R10 brk not yet at 159", int'(brk), 0);
      hold(1'b0, 1);
      chk(brk == 1'b1, "R10 brk at 160", int'(brk), 1);
      hold(1'b1, 1);
      chk(brk == 1'b0, "R10 brk clears on high", int'(brk), 0);
      chk(rx_ready == 1'b0, "R11 break with receiver off", int'(rx_ready), 0);

      // receiver back on, normal word after all of the above
      rx_en = 1'b1;
      auto_rd = 1'b1;
      hold(1'b1, 8);
      send(8'hC3, 0, 0, 1);
      drained("R4 word after re-enable");

      report();
   end
endmodule